// File: doc/BRIEF.md
# Configurable Serial Audio Input Port

This block receives two-channel PCM audio over a three-wire serial link made of a bit clock, a frame (left/right) clock and one data line. It returns each left and right sample as a parallel word, together with a one-cycle valid strobe. All logic runs on the master clock `clk`.

Static control inputs select the framing. The port can act as clock master, where it divides `clk` to drive both serial clocks itself. It can also act as slave, where it takes both clocks from the link. The other settings are the sample resolution, left or right justification, an optional one-slot gap before the first data bit, and independent inversion of each clock. Words shorter than 32 bits are returned MSB-aligned and padded with zeros.

In slave mode the three link lines pass through a two-stage synchronizer. Bit clock edges are then found in the `clk` domain. The bit clock may therefore pause between bursts, and the two halves of a frame may have different lengths. In master mode the block feeds its own generated clocks through the same synchronizer path, so received data lines up in the same way.

Top module: `audio_serial_rx`

## Requirements
- R1: In slave mode, `sclk_in`, `lrck_in` and `sdata_in` are each synchronized through two flops into `clk`. Data and frame level are sampled on each rising edge of the polarity-corrected bit clock. `clk` must run at least four times faster than the bit clock.
- R2: `cfg_res` selects the resolution: 0 for 16 bits, 1 for 20, 2 for 24 and 3 for 32. Bits arrive MSB first. Each output word holds the received bits MSB-aligned in bits [31:32-N], and all bits below are zero.
- R3: With `cfg_rjust`=0, the MSB is the bit in slot 0 of a phase when `cfg_delay`=0, or in slot 1 when `cfg_delay`=1. Slot 0 is the first sample edge after the frame level changes. Bits outside the N-slot window have no effect on the output.
- R4: With `cfg_rjust`=1, only the last N bits before the next frame level change are kept, and earlier bits in the phase have no effect. `cfg_delay` has no effect in this mode.
- R5: `cfg_bclk_inv`=1 makes the falling pin edge the sample edge. `cfg_lrck_inv`=1 inverts the frame pin, so that a pin level of 1 means left.
- R6: A corrected frame level of 0 means left and 1 means right. A left/right pair is presented with `valid_out` high for exactly one cycle at the first sample edge of the following left phase. `left_out` and `right_out` change only in that cycle.
- R7: Pauses in the bit clock and unequal left and right phase lengths do not change the received words.
- R8: In master mode, the true bit clock on `sclk_out` has a period of 2*(`cfg_div`+1) clk cycles, with `cfg_div` at least 1. `lrck_out` toggles every 32 bit clocks, on a falling true bit clock edge.
- R9: In master mode, `sdata_in` is sampled on the rising edges of the block's own true bit clock, and samples are framed by its own frame clock.
- R10: After reset, `left_out`, `right_out` and `valid_out` are 0. The phase in progress at reset is discarded, and the first pair comes from complete phases.
- R11: In slave mode, `valid_out` rises in the cycle after the third `clk` rising edge that follows the sample edge on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1: generate the serial clocks; 0: take them from the link |
| cfg_div | input | DIV_W | Master mode half bit-clock period minus one, in clk cycles |
| cfg_res | input | 2 | Resolution code (16/20/24/32 bits) |
| cfg_rjust | input | 1 | 1: right-justified framing |
| cfg_delay | input | 1 | 1: one-slot gap before the MSB (left-justified only) |
| cfg_bclk_inv | input | 1 | Invert the bit clock pin polarity |
| cfg_lrck_inv | input | 1 | Invert the frame clock pin polarity |
| sclk_in | input | 1 | Bit clock from the link (slave mode) |
| lrck_in | input | 1 | Frame clock from the link (slave mode) |
| sdata_in | input | 1 | Serial data |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated frame clock (master mode) |
| left_out | output | WORD_W | Left sample, MSB-aligned |
| right_out | output | WORD_W | Right sample, MSB-aligned |
| valid_out | output | 1 | One-cycle strobe for a new pair |

## Verification
A slave-side pin edge reaches `valid_out` after two synchronizer flops and one output register. The bench drives every pin on the falling edge of `clk`. It checks the exact strobe position at the third, and only the third, falling edge after the sample edge. For each table vector, the pair is checked only after a trailing bit of the next left phase has been sent and a few more cycles have passed, so every word has settled. In master mode the bench measures the bit clock period and the number of bit clocks per phase from the output pins. It then waits, with a bound, for the second strobe before it compares the words.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int WORD_W     = 32,
  parameter int DIV_W      = 8,
  parameter int CNT_W      = 8,
  parameter int HALF_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_res,
  input  logic              cfg_rjust,
  input  logic              cfg_delay,
  input  logic              cfg_bclk_inv,
  input  logic              cfg_lrck_inv,
  input  logic              sclk_in,
  input  logic              lrck_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              lrck_out,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              valid_out
);

  localparam int SLOT_W = $clog2(HALF_SLOTS);

  function automatic logic [CNT_W-1:0] res_bits(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(16);
      2'd1:    return CNT_W'(20);
      2'd2:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

  // clock generator (master mode)
  logic [DIV_W-1:0]  div_cnt;
  logic [SLOT_W-1:0] slot;
  logic              bclk_gen, lr_gen;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_master) begin
      div_cnt  <= '0;
      bclk_gen <= 1'b0;
      lr_gen   <= 1'b0;
      slot     <= '0;
    end else if (div_cnt == cfg_div) begin
      div_cnt  <= '0;
      bclk_gen <= ~bclk_gen;
      if (bclk_gen) begin
        slot <= slot + 1'b1;
        if (slot == SLOT_W'(HALF_SLOTS - 1)) lr_gen <= ~lr_gen;
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign sclk_out = bclk_gen ^ cfg_bclk_inv;
  assign lrck_out = lr_gen ^ cfg_lrck_inv;

  // synchronizers; master mode loops its own clocks back
  logic [2:0] sy_b;
  logic [1:0] sy_l, sy_d;
  wire b_pin = cfg_master ? sclk_out : sclk_in;
  wire l_pin = cfg_master ? lrck_out : lrck_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy_b <= {3{cfg_bclk_inv}};
      sy_l <= '0;
      sy_d <= '0;
    end else begin
      sy_b <= {sy_b[1:0], b_pin};
      sy_l <= {sy_l[0], l_pin};
      sy_d <= {sy_d[0], sdata_in};
    end
  end

  wire bit_ev = (sy_b[1] ^ cfg_bclk_inv) & ~(sy_b[2] ^ cfg_bclk_inv);
  wire lr_now = sy_l[1] ^ cfg_lrck_inv;
  wire d_now  = sy_d[1];

  // receiver
  logic              seen, primed, prev_lr, left_ok;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr, left_hold;

  wire [CNT_W-1:0] nbits   = res_bits(cfg_res);
  wire             new_ph  = !seen || (lr_now != prev_lr);
  wire             edge_ph = seen && (lr_now != prev_lr);
  wire [CNT_W-1:0] idx     = new_ph ? '0 : cnt_q;
  wire [CNT_W-1:0] dly     = {{(CNT_W-1){1'b0}}, cfg_delay};
  wire             take    = cfg_rjust || ((idx >= dly) && (idx < dly + nbits));
  wire [WORD_W-1:0] sr_base = (new_ph && !cfg_rjust) ? '0 : sr;
  wire [WORD_W-1:0] sr_next = take ? {sr_base[WORD_W-2:0], d_now} : sr_base;
  wire [WORD_W-1:0] word    = sr << (WORD_W - int'(nbits));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      primed    <= 1'b0;
      prev_lr   <= 1'b0;
      left_ok   <= 1'b0;
      cnt_q     <= '0;
      sr        <= '0;
      left_hold <= '0;
      left_out  <= '0;
      right_out <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= 1'b0;
      if (bit_ev) begin
        seen    <= 1'b1;
        prev_lr <= lr_now;
        sr      <= sr_next;
        cnt_q   <= (idx == '1) ? idx : idx + 1'b1;
        if (edge_ph) begin
          primed <= 1'b1;
          if (primed && !prev_lr) begin
            left_hold <= word;
            left_ok   <= 1'b1;
          end else if (primed && left_ok) begin
            left_out  <= left_hold;
            right_out <= word;
            valid_out <= 1'b1;
            left_ok   <= 1'b0;
          end
        end
      end
    end
  end

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> !valid_out);

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> ($stable(left_out) && $stable(right_out)));

  p_zero_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (((left_out | right_out) & ~({WORD_W{1'b1}} << (WORD_W - int'(res_bits(cfg_res))))) == '0));

  p_lr_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && (lr_gen != $past(lr_gen))) |-> $fell(bclk_gen));

  p_bclk_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && (cfg_div != '0) && !$stable(bclk_gen)) |=> (!cfg_master || $stable(bclk_gen)));

endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NV = 7;

  // {res[86:85], rj, dly, binv, linv, gap, lslots[79:72], rslots[71:64], L, R}
  localparam logic [86:0] VECS [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16, 8'd16, 32'h9ABC_DEF1, 32'h1357_9BDF},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd40, 8'd40, 32'hDEAD_BEEF, 32'h0123_4567},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd32, 8'd28, 32'hA5A5_3C00, 32'h7E81_9900},
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd32, 8'd32, 32'hF0F0_F000, 32'h8421_7000},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd24, 8'd40, 32'h1122_3300, 32'hCCBB_AA00},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd20, 8'd36, 32'h8001_0000, 32'h7FFE_0000},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd32, 8'd48, 32'hCAFE_F00D, 32'h0BAD_C0DE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_rjust = 1'b0, cfg_delay = 1'b0;
  logic cfg_bclk_inv = 1'b0, cfg_lrck_inv = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic [1:0] cfg_res = 2'd0;
  logic sclk_in = 1'b0, lrck_in = 1'b0, sdata_in = 1'b0;
  logic sclk_out, lrck_out, valid_out;
  logic [31:0] left_out, right_out;

  int checks = 0, fails = 0, vcount = 0, cyc = 0;
  logic [31:0] cap_l = '0, cap_r = '0;
  bit master_feed = 1'b0;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .cfg_res(cfg_res), .cfg_rjust(cfg_rjust), .cfg_delay(cfg_delay),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_lrck_inv(cfg_lrck_inv),
    .sclk_in(sclk_in), .lrck_in(lrck_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .lrck_out(lrck_out),
    .left_out(left_out), .right_out(right_out), .valid_out(valid_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (valid_out) begin
    vcount = vcount + 1;
    cap_l = left_out;
    cap_r = right_out;
  end

  // master mode: drive data on true falling edges, measure the generated clocks
  localparam logic [31:0] ML = 32'hC0FF_EE12, MR = 32'h0BAD_F00D;
  bit prev_tb = 1'b0, last_lr = 1'b0, prev_lrck = 1'b0;
  int midx = 0, rises = 0, last_rise = -1, period = 0, phase_rises = 0;
  always @(negedge clk) if (master_feed) begin
    automatic bit tb = sclk_out ^ cfg_bclk_inv;
    automatic bit lrt = lrck_out ^ cfg_lrck_inv;
    automatic logic [31:0] w = lrt ? MR : ML;
    if (prev_tb && !tb) begin
      if (lrt != last_lr) midx = 0; else midx = midx + 1;
      last_lr = lrt;
      sdata_in = (midx < 24) ? w[31-midx] : 1'b1;
    end
    if (!prev_tb && tb) begin
      if (last_rise >= 0) period = cyc - last_rise;
      last_rise = cyc;
      rises = rises + 1;
    end
    if (lrck_out != prev_lrck) begin
      phase_rises = rises;
      rises = 0;
    end
    prev_lrck = lrck_out;
    prev_tb = tb;
  end

  function automatic logic [31:0] msk(int n);
    return ~32'h0 << (32 - n);
  endfunction

  function automatic int nb_of(logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(logic lrt, logic d);
    sclk_in = cfg_bclk_inv;
    lrck_in = lrt ^ cfg_lrck_inv;
    sdata_in = d;
    tick(HALF);
    sclk_in = ~cfg_bclk_inv;
    tick(HALF);
  endtask

  task automatic send_phase(logic lrt, logic [31:0] w, int nb, bit rj, bit dly, int slots, bit gap);
    for (int i = 0; i < slots; i++) begin
      automatic int pos = rj ? i - (slots - nb) : i - int'(dly);
      sbit(lrt, (pos >= 0 && pos < nb) ? w[31-pos] : 1'b1);
      if (gap && (i % 8 == 7)) tick(20);
    end
  endtask

  task automatic do_reset();
    tick(1);
    rst_n = 1'b0;
    sclk_in = cfg_bclk_inv;
    lrck_in = 1'b1 ^ cfg_lrck_inv;
    sdata_in = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    fails = fails + 1;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // table walk (slave mode)
    for (int i = 0; i < NV; i++) begin
      automatic logic [86:0] v = VECS[i];
      automatic int nb = nb_of(v[86:85]);
      automatic int ls = int'(v[79:72]);
      automatic int rs = int'(v[71:64]);
      cfg_res = v[86:85]; cfg_rjust = v[84]; cfg_delay = v[83];
      cfg_bclk_inv = v[82]; cfg_lrck_inv = v[81];
      do_reset();
      check(valid_out == 1'b0 && left_out == '0 && right_out == '0, "R10 reset state",
            left_out | right_out, 32'h0);
      vcount = 0;
      send_phase(1'b1, 32'hFFFF_FFFF, nb, v[84], v[83], 4, 1'b0);
      send_phase(1'b0, v[63:32], nb, v[84], v[83], ls, v[80]);
      send_phase(1'b1, v[31:0], nb, v[84], v[83], rs, v[80]);
      sbit(1'b0, 1'b0);
      tick(4);
      check(vcount == 1, "R6 R10 one strobe per pair", 32'(vcount), 32'd1);
      check(cap_l == (v[63:32] & msk(nb)), "R2 R3 R4 R5 R7 left word", cap_l, v[63:32] & msk(nb));
      check(cap_r == (v[31:0] & msk(nb)), "R1 R2 R3 R4 R5 R7 right word", cap_r, v[31:0] & msk(nb));
    end

    // R11: strobe latency from the pin sample edge
    cfg_res = 2'd0; cfg_rjust = 1'b0; cfg_delay = 1'b0;
    cfg_bclk_inv = 1'b0; cfg_lrck_inv = 1'b0;
    do_reset();
    send_phase(1'b1, 32'hFFFF_FFFF, 16, 1'b0, 1'b0, 4, 1'b0);
    send_phase(1'b0, 32'h4444_0000, 16, 1'b0, 1'b0, 16, 1'b0);
    send_phase(1'b1, 32'h5555_0000, 16, 1'b0, 1'b0, 16, 1'b0);
    sclk_in = 1'b0; lrck_in = 1'b0; sdata_in = 1'b0;
    tick(HALF);
    sclk_in = 1'b1;
    tick(1); check(valid_out == 1'b0, "R11 no strobe after edge 1", 32'(valid_out), 32'd0);
    tick(1); check(valid_out == 1'b0, "R11 no strobe after edge 2", 32'(valid_out), 32'd0);
    tick(1); check(valid_out == 1'b1, "R11 strobe after edge 3", 32'(valid_out), 32'd1);
    tick(1); check(valid_out == 1'b0, "R6 strobe lasts one cycle", 32'(valid_out), 32'd0);
    check(left_out == 32'h4444_0000, "R6 left held", left_out, 32'h4444_0000);

    // R8 R9: master mode
    cfg_master = 1'b1; cfg_div = 8'd2; cfg_res = 2'd2; cfg_rjust = 1'b0;
    cfg_delay = 1'b0; cfg_bclk_inv = 1'b1; cfg_lrck_inv = 1'b0;
    do_reset();
    vcount = 0;
    master_feed = 1'b1;
    for (int t = 0; t < 5000 && vcount < 2; t++) tick(1);
    check(vcount >= 2, "R9 master strobes seen", 32'(vcount), 32'd2);
    check(period == 6, "R8 bit clock period", 32'(period), 32'd6);
    check(phase_rises == 32, "R8 bit clocks per phase", 32'(phase_rises), 32'd32);
    check(cap_l == (ML & msk(24)), "R9 master left word", cap_l, ML & msk(24));
    check(cap_r == (MR & msk(24)), "R9 master right word", cap_r, MR & msk(24));
    master_feed = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule